// File: doc/BRIEF.md
# PWM Action Qualifier with Double-Buffered Event Tables

This block turns the events of an external time-base counter into two pulse-width-modulated outputs, `pwm_a` and `pwm_b`. Every cycle it compares the counter value against zero, against the period, and against two compare values. Each compare match is split into an up-count case and a down-count case, selected by the counting direction. For each output, a 12-bit event table gives one of four actions per event: no action, drive low, drive high or toggle. When several events occur together, a fixed priority chooses one of them.

Each event table has an active copy and a shadow copy. A per-output configuration lane chooses between two write modes. In immediate mode a write goes straight to the active copy. In buffered mode a write goes to the shadow copy, which moves into the active copy on a selected counter boundary, on a sync pulse, or never. Software can also force each output: once through a one-shot action, or continuously until the force is released.

All register writes go through one write strobe with an address and a data word. The counter, its direction, the period and the compare values are inputs that come from elsewhere.

Top module: `pwm_action_qual`

## Requirements
- R1: Each output's event table packs six 2-bit fields. Bits [1:0] are the counter-equals-zero action, [3:2] the counter-equals-period action, [5:4] compare A while counting up, [7:6] compare A while counting down, [9:8] compare B while counting up, and [11:10] compare B while counting down. The action codes are 00 no action, 01 drive low, 10 drive high and 11 toggle. The output is registered and changes at the clock edge that ends the cycle in which the event is presented.
- R2: A compare match counts as an up-count event only when `cnt_up` is 1 and as a down-count event only when `cnt_up` is 0. An action placed on one half has no effect on the other half.
- R3: When several events occur in the same cycle, only events whose field is not 00 compete. The priority from highest to lowest is compare B, compare A, zero, period.
- R4: Each output has a 5-bit configuration lane: A in bits [4:0] of the configuration word, B in bits [12:8]. Lane bit 0 set to 1 selects immediate mode: a table write reaches the active copy at the next edge, and no shadow transfer takes place.
- R5: With lane bit 0 at 0, a table write goes only to the shadow copy. The outputs keep following the old active table until a transfer occurs.
- R6: Lane bits [2:1] choose the transfer boundary: 00 counter equal zero, 01 counter equal period, 10 either of the two, 11 frozen. When frozen, no transfer occurs, whatever the sync input does.
- R7: Lane bits [4:3] qualify the transfer. 00 transfers on the boundary only. 01 transfers on the boundary or on `sync_in`. 10 transfers on `sync_in` only. 11 behaves as 00.
- R8: A transfer is visible from the cycle after its triggering cycle. The event in the triggering cycle is acted on with the old active table.
- R9: A one-shot force word (A in bits [1:0], B in bits [3:2], using the action codes) is applied once, at the edge after the write edge. It overrides all events, and the output is left alone afterwards.
- R10: A continuous force word (A in bits [1:0], B in bits [3:2]) holds an output low with 01 and high with 10, starting from the edge after the write. It overrides all other actions. Codes 00 and 11 release the output.
- R11: Reset drives both outputs low, clears the tables, configuration and forces, and leaves both lanes in buffered mode with zero boundary and no sync qualification.
- R12: Write addresses are 0 table A, 1 table B, 2 configuration, 3 one-shot force, 4 continuous force. Writes to any other address have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cnt | input | CW | Time-base counter value |
| cnt_up | input | 1 | 1 while the counter counts up, 0 while it counts down |
| period | input | CW | Period value for the period-match event |
| cmp_a | input | CW | Compare A value |
| cmp_b | input | CW | Compare B value |
| sync_in | input | 1 | Sync pulse that can qualify shadow transfers |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | AW | Register write address |
| wr_data | input | DW | Register write data |
| pwm_a | output | 1 | Output A |
| pwm_b | output | 1 | Output B |

## Verification
Directed single-cycle steps present one counter value and direction at a time. They separate the up-count and down-count halves of a compare, show which of two coincident events wins, and show whether a shadowed table has moved over, by choosing tables whose old and new contents would give different output levels. Four triangular sweeps are then compared cycle by cycle with an independent model in the bench:
- equal compare values;
- a compare sitting on the period and one on zero;
- sync-qualified transfers;
- frozen transfers.

Each sweep also rewrites table A in the middle of the run, so the cycle of the shadow hand-over is checked at every boundary kind.

// File: rtl/pwmaq_pkg.sv
package pwmaq_pkg;

   typedef enum logic [1:0] {
      ACT_NONE   = 2'b00,
      ACT_LOW    = 2'b01,
      ACT_HIGH   = 2'b10,
      ACT_TOGGLE = 2'b11
   } act_e;

   // field order fixes the bit layout of a table write (MSB first)
   typedef struct packed {
      act_e cb_dn;
      act_e cb_up;
      act_e ca_dn;
      act_e ca_up;
      act_e at_prd;
      act_e at_zero;
   } act_tbl_t;

   typedef enum logic [1:0] {
      LD_ZERO   = 2'b00,
      LD_PRD    = 2'b01,
      LD_EITHER = 2'b10,
      LD_FREEZE = 2'b11
   } ld_sel_e;

   typedef enum logic [1:0] {
      SY_NONE = 2'b00,
      SY_OR   = 2'b01,
      SY_ONLY = 2'b10,
      SY_RSVD = 2'b11
   } sy_sel_e;

   typedef struct packed {
      sy_sel_e sync_sel;
      ld_sel_e ld_sel;
      logic    imm;
   } ld_cfg_t;

   typedef struct packed {
      logic zero;
      logic prd;
      logic ca_up;
      logic ca_dn;
      logic cb_up;
      logic cb_dn;
   } evt_t;

   typedef enum logic [1:0] {
      CF_OFF  = 2'b00,
      CF_LOW  = 2'b01,
      CF_HIGH = 2'b10,
      CF_IDLE = 2'b11
   } cf_e;

   localparam int unsigned ADDR_TBL0    = 0;
   localparam int unsigned ADDR_CFG     = 2;
   localparam int unsigned ADDR_ONESHOT = 3;
   localparam int unsigned ADDR_CONT    = 4;
   localparam int unsigned CFG_LANE     = 8;
   localparam int unsigned FRC_LANE     = 2;

endpackage

// File: rtl/pwmaq_evt_decode.sv
module pwmaq_evt_decode
   import pwmaq_pkg::*;
#(
   parameter int CW = 16
) (
   input  logic [CW-1:0] cnt,
   input  logic          cnt_up,
   input  logic [CW-1:0] period,
   input  logic [CW-1:0] cmp_a,
   input  logic [CW-1:0] cmp_b,
   output evt_t          evt
);

   logic hit_a;
   logic hit_b;

   assign hit_a = (cnt == cmp_a);
   assign hit_b = (cnt == cmp_b);

   always_comb begin
      evt.zero  = (cnt == '0);
      evt.prd   = (cnt == period);
      evt.ca_up = hit_a &&  cnt_up;
      evt.ca_dn = hit_a && !cnt_up;
      evt.cb_up = hit_b &&  cnt_up;
      evt.cb_dn = hit_b && !cnt_up;
   end

   // R2: the two halves of one compare never fire together
   always_comb begin
      assert_dir_split_R2: assert ($countones({evt.ca_up, evt.ca_dn}) <= 1
                                   && $countones({evt.cb_up, evt.cb_dn}) <= 1);
   end

endmodule

// File: rtl/pwmaq_tbl_buffer.sv
module pwmaq_tbl_buffer
   import pwmaq_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  ld_cfg_t  cfg,
   input  logic     at_zero,
   input  logic     at_prd,
   input  logic     sync_in,
   input  logic     wr_tbl,
   input  act_tbl_t wr_val,
   output act_tbl_t active
);

   act_tbl_t shadow_q;
   act_tbl_t active_q;
   logic     bound_hit;
   logic     load_go;

   always_comb begin
      unique case (cfg.ld_sel)
         LD_ZERO:   bound_hit = at_zero;
         LD_PRD:    bound_hit = at_prd;
         LD_EITHER: bound_hit = at_zero || at_prd;
         LD_FREEZE: bound_hit = 1'b0;
      endcase
   end

   always_comb begin
      unique case (cfg.sync_sel)
         SY_OR:   load_go = bound_hit || sync_in;
         SY_ONLY: load_go = sync_in;
         SY_NONE,
         SY_RSVD: load_go = bound_hit;
      endcase
      if (cfg.ld_sel == LD_FREEZE || cfg.imm) begin
         load_go = 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         active_q <= '0;
         shadow_q <= '0;
      end else begin
         if (wr_tbl && cfg.imm) begin
            active_q <= wr_val;
         end else if (load_go) begin
            active_q <= shadow_q;
         end
         if (wr_tbl && !cfg.imm) begin
            shadow_q <= wr_val;
         end
      end
   end

   assign active = active_q;

   assert_freeze_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg.ld_sel == LD_FREEZE && !(wr_tbl && cfg.imm)) |=> $stable(active_q));

   assert_imm_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_tbl && cfg.imm) |=> (active_q == $past(wr_val)));

   assert_shadow_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_tbl && !cfg.imm && !sync_in && !at_zero && !at_prd) |=> $stable(active_q));

endmodule

// File: rtl/pwmaq_out_stage.sv
module pwmaq_out_stage
   import pwmaq_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  act_tbl_t tbl,
   input  evt_t     evt,
   input  act_e     os_act,
   input  cf_e      cf,
   output logic     pwm
);

   act_e pick;
   logic pwm_q;
   logic pwm_nxt;

   // later assignments win: lowest priority first
   always_comb begin
      pick = ACT_NONE;
      if (evt.prd   && tbl.at_prd  != ACT_NONE) pick = tbl.at_prd;
      if (evt.zero  && tbl.at_zero != ACT_NONE) pick = tbl.at_zero;
      if (evt.ca_dn && tbl.ca_dn   != ACT_NONE) pick = tbl.ca_dn;
      if (evt.ca_up && tbl.ca_up   != ACT_NONE) pick = tbl.ca_up;
      if (evt.cb_dn && tbl.cb_dn   != ACT_NONE) pick = tbl.cb_dn;
      if (evt.cb_up && tbl.cb_up   != ACT_NONE) pick = tbl.cb_up;
      if (os_act != ACT_NONE)                   pick = os_act;
   end

   always_comb begin
      unique case (pick)
         ACT_NONE:   pwm_nxt = pwm_q;
         ACT_LOW:    pwm_nxt = 1'b0;
         ACT_HIGH:   pwm_nxt = 1'b1;
         ACT_TOGGLE: pwm_nxt = !pwm_q;
      endcase
      if (cf == CF_LOW) begin
         pwm_nxt = 1'b0;
      end else if (cf == CF_HIGH) begin
         pwm_nxt = 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pwm_q <= 1'b0;
      end else begin
         pwm_q <= pwm_nxt;
      end
   end

   assign pwm = pwm_q;

   assert_cf_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (cf == CF_LOW) |=> !pwm_q);

   assert_cf_high_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (cf == CF_HIGH) |=> pwm_q);

   assert_oneshot_high_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (os_act == ACT_HIGH && cf != CF_LOW) |=> pwm_q);

   assert_cb_over_ca_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (cf == CF_OFF && os_act == ACT_NONE && evt.cb_up && tbl.cb_up == ACT_HIGH)
      |=> pwm_q);

   assert_quiet_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (cf != CF_LOW && cf != CF_HIGH && os_act == ACT_NONE
       && !(evt.zero || evt.prd || evt.ca_up || evt.ca_dn || evt.cb_up || evt.cb_dn))
      |=> $stable(pwm_q));

endmodule

// File: rtl/pwm_action_qual.sv
module pwm_action_qual
   import pwmaq_pkg::*;
#(
   parameter int CW = 16,
   parameter int AW = 3,
   parameter int DW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [CW-1:0] cnt,
   input  logic          cnt_up,
   input  logic [CW-1:0] period,
   input  logic [CW-1:0] cmp_a,
   input  logic [CW-1:0] cmp_b,
   input  logic          sync_in,
   input  logic          wr_en,
   input  logic [AW-1:0] wr_addr,
   input  logic [DW-1:0] wr_data,
   output logic          pwm_a,
   output logic          pwm_b
);

   localparam int NCH    = 2;
   localparam int TBL_W  = $bits(act_tbl_t);
   localparam int CFG_W  = $bits(ld_cfg_t);
   localparam int FRC_W  = $bits(cf_e);
   localparam int USED_W = CFG_LANE * (NCH - 1) + CFG_W;

   if (CW < 2) begin : g_chk_cw
      $error("counter width must be at least 2");
   end
   if (AW < 3) begin : g_chk_aw
      $error("address width must reach address 4");
   end
   if (DW <= USED_W || DW < TBL_W) begin : g_chk_dw
      $error("data width too narrow for the configuration word");
   end

   evt_t             evt;
   logic             wr_cfg;
   logic             wr_os;
   logic             wr_cf;
   logic [NCH-1:0]   pwm_q;
   logic             unused_hi;

   assign wr_cfg    = wr_en && (wr_addr == AW'(ADDR_CFG));
   assign wr_os     = wr_en && (wr_addr == AW'(ADDR_ONESHOT));
   assign wr_cf     = wr_en && (wr_addr == AW'(ADDR_CONT));
   assign unused_hi = ^wr_data[DW-1:USED_W];

   pwmaq_evt_decode #(.CW(CW)) u_evt (
      .cnt    (cnt),
      .cnt_up (cnt_up),
      .period (period),
      .cmp_a  (cmp_a),
      .cmp_b  (cmp_b),
      .evt    (evt)
   );

   for (genvar c = 0; c < NCH; c++) begin : g_ch
      logic     wr_tbl;
      ld_cfg_t  cfg_q;
      act_e     os_q;
      cf_e      cf_q;
      act_tbl_t act_tbl;

      assign wr_tbl = wr_en && (wr_addr == AW'(ADDR_TBL0 + c));

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            cfg_q <= '0;
            os_q  <= ACT_NONE;
            cf_q  <= CF_OFF;
         end else begin
            if (wr_cfg) begin
               cfg_q <= ld_cfg_t'(wr_data[c*CFG_LANE +: CFG_W]);
            end
            os_q <= wr_os ? act_e'(wr_data[c*FRC_LANE +: FRC_W]) : ACT_NONE;
            if (wr_cf) begin
               cf_q <= cf_e'(wr_data[c*FRC_LANE +: FRC_W]);
            end
         end
      end

      pwmaq_tbl_buffer u_buf (
         .clk     (clk),
         .rst_n   (rst_n),
         .cfg     (cfg_q),
         .at_zero (evt.zero),
         .at_prd  (evt.prd),
         .sync_in (sync_in),
         .wr_tbl  (wr_tbl),
         .wr_val  (act_tbl_t'(wr_data[TBL_W-1:0])),
         .active  (act_tbl)
      );

      pwmaq_out_stage u_out (
         .clk    (clk),
         .rst_n  (rst_n),
         .tbl    (act_tbl),
         .evt    (evt),
         .os_act (os_q),
         .cf     (cf_q),
         .pwm    (pwm_q[c])
      );

      assert_oneshot_once_R9: assert property (@(posedge clk) disable iff (!rst_n)
         (os_q != ACT_NONE && !wr_os) |=> (os_q == ACT_NONE));
   end

   assign pwm_a = pwm_q[0];
   assign pwm_b = pwm_q[1];

endmodule

// File: tb/sim_pwm_action_qual.sv
module sim_pwm_action_qual;

   localparam int CLK_PERIOD = 10;
   localparam int MAX_CYCLES = 20000;
   localparam logic [15:0] IDLE = 16'd1000;

   typedef struct packed {
      logic [15:0] prd;
      logic [15:0] ca;
      logic [15:0] cb;
      logic [15:0] ta;
      logic [15:0] tb;
      logic [15:0] cfg;
      logic [15:0] ta2;
      logic [15:0] cycles;
   } vec_t;

   localparam vec_t VECS [4] = '{
      '{16'd10, 16'd3,  16'd7, 16'h420, 16'h009, 16'h0000, 16'h0C0, 16'd60},
      '{16'd7,  16'd2,  16'd2, 16'hFFF, 16'h5A5, 16'h0404, 16'h111, 16'd50},
      '{16'd12, 16'd12, 16'd0, 16'h033, 16'h3C3, 16'h120A, 16'h2A9, 16'd80},
      '{16'd5,  16'd4,  16'd1, 16'h6C9, 16'h936, 16'h0606, 16'h000, 16'd40}
   };

   logic        clk = 0;
   logic        rst_n = 0;
   logic [15:0] cnt = IDLE;
   logic        cnt_up = 1;
   logic [15:0] period = 16'd8;
   logic [15:0] cmp_a = 16'd2;
   logic [15:0] cmp_b = 16'd5;
   logic        sync_in = 0;
   logic        wr_en = 0;
   logic [2:0]  wr_addr = 0;
   logic [15:0] wr_data = 0;
   logic        pwm_a;
   logic        pwm_b;

   int  n_tests = 0;
   int  n_fail  = 0;
   bit  chk_on  = 0;
   bit  run     = 0;
   bit  done    = 0;
   int  tick    = 0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   pwm_action_qual u0 (
      .clk(clk), .rst_n(rst_n), .cnt(cnt), .cnt_up(cnt_up), .period(period),
      .cmp_a(cmp_a), .cmp_b(cmp_b), .sync_in(sync_in), .wr_en(wr_en),
      .wr_addr(wr_addr), .wr_data(wr_data), .pwm_a(pwm_a), .pwm_b(pwm_b)
   );

   // behavioural model built from the requirements
   logic [11:0] m_act [2];
   logic [11:0] m_sh  [2];
   logic [4:0]  m_cfg [2];
   logic [1:0]  m_os  [2];
   logic [1:0]  m_cf  [2];
   logic        m_out [2];

   function automatic logic next_out(input logic cur, input logic [11:0] t,
                                     input logic [1:0] os, input logic [1:0] cf,
                                     input logic z, input logic p, input logic au,
                                     input logic ad, input logic bu, input logic bd);
      logic [1:0] a;
      if (cf == 2'b01) return 1'b0;
      if (cf == 2'b10) return 1'b1;
      if (os != 0)                     a = os;
      else if (bu && t[9:8]   != 0)    a = t[9:8];
      else if (bd && t[11:10] != 0)    a = t[11:10];
      else if (au && t[5:4]   != 0)    a = t[5:4];
      else if (ad && t[7:6]   != 0)    a = t[7:6];
      else if (z  && t[1:0]   != 0)    a = t[1:0];
      else if (p  && t[3:2]   != 0)    a = t[3:2];
      else                             a = 2'b00;
      case (a)
         2'b01:   return 1'b0;
         2'b10:   return 1'b1;
         2'b11:   return !cur;
         default: return cur;
      endcase
   endfunction

   function automatic logic load_now(input logic [4:0] cf, input logic z,
                                     input logic p, input logic s);
      logic lm;
      if (cf[0] || cf[2:1] == 2'b11) return 1'b0;
      lm = (cf[2:1] == 2'b00) ? z : (cf[2:1] == 2'b01) ? p : (z | p);
      case (cf[4:3])
         2'b01:   return lm | s;
         2'b10:   return s;
         default: return lm;
      endcase
   endfunction

   always @(posedge clk) begin
      for (int c = 0; c < 2; c++) begin
         if (!rst_n) begin
            m_act[c] <= 0; m_sh[c] <= 0; m_cfg[c] <= 0;
            m_os[c] <= 0; m_cf[c] <= 0; m_out[c] <= 0;
         end else begin
            m_out[c] <= next_out(m_out[c], m_act[c], m_os[c], m_cf[c],
                                 cnt == 0, cnt == period,
                                 cnt == cmp_a && cnt_up, cnt == cmp_a && !cnt_up,
                                 cnt == cmp_b && cnt_up, cnt == cmp_b && !cnt_up);
            if (wr_en && wr_addr == c && m_cfg[c][0])
               m_act[c] <= wr_data[11:0];
            else if (load_now(m_cfg[c], cnt == 0, cnt == period, sync_in))
               m_act[c] <= m_sh[c];
            if (wr_en && wr_addr == c && !m_cfg[c][0])
               m_sh[c] <= wr_data[11:0];
            if (wr_en && wr_addr == 3'd2)
               m_cfg[c] <= wr_data[c*8 +: 5];
            m_os[c] <= (wr_en && wr_addr == 3'd3) ? wr_data[c*2 +: 2] : 2'b00;
            if (wr_en && wr_addr == 3'd4)
               m_cf[c] <= wr_data[c*2 +: 2];
         end
      end
   end

   // cycle-by-cycle comparison against the model (R1 R2 R3 R8)
   always @(negedge clk) begin
      if (chk_on) begin
         n_tests++;
         if (pwm_a !== m_out[0] || pwm_b !== m_out[1]) begin
            n_fail++;
            $display("FAIL R1 R3 R8 model compare t=%0t: got a=%0b b=%0b expected a=%0b b=%0b",
                     $time, pwm_a, pwm_b, m_out[0], m_out[1]);
         end
      end
   end

   // free-running up-down counter used by the sweeps
   always @(negedge clk) begin
      if (run) begin
         tick++;
         sync_in = (tick % 13 == 5);
         if (cnt_up) begin
            if (cnt >= period) begin cnt_up = 0; cnt = cnt - 1; end
            else cnt = cnt + 1;
         end else begin
            if (cnt == 0) begin cnt_up = 1; cnt = 1; end
            else cnt = cnt - 1;
         end
      end
   end

   task automatic chk(input string tag, input logic act, input logic exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: got %0b expected %0b", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [15:0] d);
      wr_en = 1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 0;
   endtask

   task automatic step(input logic [15:0] c, input logic d, input logic s);
      cnt = c; cnt_up = d; sync_in = s;
      @(negedge clk);
      cnt = IDLE; sync_in = 0;
   endtask

   task automatic do_reset();
      chk_on = 0;
      rst_n = 0;
      repeat (3) @(negedge clk);
      rst_n = 1;
      chk_on = 1;
   endtask

   initial begin
      repeat (MAX_CYCLES) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      @(negedge clk);
      do_reset();
      chk("R11 reset a", pwm_a, 1'b0);
      chk("R11 reset b", pwm_b, 1'b0);

      // basic mapping, immediate mode
      wr(3'd2, 16'h0101);
      wr(3'd0, 16'h0420);
      wr(3'd1, 16'h0009);
      step(16'd2, 1, 0); chk("R1 set on compare A up", pwm_a, 1'b1);
      step(16'd2, 0, 0); chk("R2 compare A down has no action", pwm_a, 1'b1);
      step(16'd5, 1, 0); chk("R2 compare B up has no action", pwm_a, 1'b1);
      step(16'd5, 0, 0); chk("R1 clear on compare B down", pwm_a, 1'b0);
      step(16'd8, 1, 0); chk("R1 B set on period", pwm_b, 1'b1);
      step(16'd0, 0, 0); chk("R1 B clear on zero", pwm_b, 1'b0);

      // priority
      cmp_b = 16'd2;
      wr(3'd0, 16'h0210);
      step(16'd2, 1, 0); chk("R3 compare B beats compare A", pwm_a, 1'b1);
      wr(3'd0, 16'h0010);
      step(16'd2, 1, 0); chk("R3 no-action field does not compete", pwm_a, 1'b0);
      period = 16'd0;
      wr(3'd0, 16'h0006);
      step(16'd0, 0, 0); chk("R3 zero beats period", pwm_a, 1'b1);
      period = 16'd8;
      cmp_b = 16'd5;

      // toggle
      wr(3'd0, 16'h0030);
      step(16'd2, 1, 0); chk("R1 toggle low", pwm_a, 1'b0);
      step(16'd2, 1, 0); chk("R1 toggle high", pwm_a, 1'b1);

      // one-shot force
      wr(3'd3, 16'h0001);
      chk("R9 one-shot not yet applied", pwm_a, 1'b1);
      @(negedge clk); chk("R9 one-shot clear applied", pwm_a, 1'b0);
      wr(3'd3, 16'h000C);
      @(negedge clk); chk("R9 one-shot toggle on B", pwm_b, 1'b1);

      // shadow transfer on period
      wr(3'd0, 16'h003C);
      wr(3'd2, 16'h0102);
      wr(3'd0, 16'h0018);
      step(16'd2, 1, 0); chk("R5 old table still active", pwm_a, 1'b1);
      step(16'd8, 1, 0); chk("R8 load event uses old table", pwm_a, 1'b0);
      step(16'd8, 1, 0); chk("R5 new table after period", pwm_a, 1'b1);
      step(16'd2, 1, 0); chk("R5 new compare action", pwm_a, 1'b0);

      // sync qualified transfers
      wr(3'd2, 16'h0110);
      wr(3'd0, 16'h0030);
      step(16'd0, 0, 0);
      step(16'd2, 1, 0); chk("R7 sync-only ignores zero", pwm_a, 1'b0);
      step(IDLE, 1, 1);
      step(16'd2, 1, 0); chk("R7 sync-only loads on sync", pwm_a, 1'b1);
      wr(3'd2, 16'h0108);
      wr(3'd0, 16'h0010);
      step(IDLE, 1, 1);
      step(16'd2, 1, 0); chk("R7 boundary-or-sync loads on sync", pwm_a, 1'b0);

      // freeze and reserved sync code
      wr(3'd2, 16'h0116);
      wr(3'd0, 16'h0020);
      step(16'd0, 0, 0);
      step(16'd8, 1, 0);
      step(IDLE, 1, 1);
      step(16'd2, 1, 0); chk("R6 frozen table never loads", pwm_a, 1'b0);
      wr(3'd2, 16'h011A);
      step(IDLE, 1, 1);
      step(16'd2, 1, 0); chk("R7 reserved sync code ignores sync", pwm_a, 1'b0);
      step(16'd8, 1, 0);
      step(16'd2, 1, 0); chk("R6 period boundary loads", pwm_a, 1'b1);

      // continuous force
      wr(3'd4, 16'h0001);
      chk("R10 force not yet applied", pwm_a, 1'b1);
      @(negedge clk); chk("R10 force low", pwm_a, 1'b0);
      step(16'd2, 1, 0); chk("R10 force low beats set event", pwm_a, 1'b0);
      wr(3'd4, 16'h0002);
      @(negedge clk); chk("R10 force high", pwm_a, 1'b1);
      wr(3'd2, 16'h0101);
      wr(3'd0, 16'h0010);
      step(16'd2, 1, 0); chk("R10 force high beats clear event", pwm_a, 1'b1);
      wr(3'd4, 16'h0003);
      step(16'd2, 1, 0); chk("R10 code 11 releases output", pwm_a, 1'b0);

      // unmapped addresses
      wr(3'd6, 16'hFFFF);
      wr(3'd7, 16'hFFFF);
      step(16'd2, 1, 0);
      chk("R12 unmapped write leaves A", pwm_a, 1'b0);
      chk("R12 unmapped write leaves B", pwm_b, 1'b1);

      do_reset();
      chk("R11 reset after activity a", pwm_a, 1'b0);
      chk("R11 reset after activity b", pwm_b, 1'b0);

      // sweep table against the model, with a mid-run shadow write (R4 R5 R6 R7 R8)
      for (int i = 0; i < 4; i++) begin
         run = 0;
         cnt = 16'd0; cnt_up = 1;
         period = VECS[i].prd; cmp_a = VECS[i].ca; cmp_b = VECS[i].cb;
         wr(3'd2, 16'h0101);
         wr(3'd0, VECS[i].ta);
         wr(3'd1, VECS[i].tb);
         wr(3'd4, 16'h0000);
         wr(3'd2, VECS[i].cfg);
         wr(3'd0, VECS[i].ta);
         wr(3'd1, VECS[i].tb);
         run = 1;
         repeat (int'(VECS[i].cycles) / 2) @(negedge clk);
         wr(3'd0, VECS[i].ta2);
         repeat (int'(VECS[i].cycles) / 2) @(negedge clk);
         run = 0;
         cnt = IDLE;
         sync_in = 0;
         @(negedge clk);
      end

      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule